// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the master side of a three-wire link to a 10-bit successive-approximation converter. The link has an active-low chip select, a serial clock that the controller drives, and one data line from the converter. A start request pulls chip select low, which begins a conversion. The controller then holds the serial clock low until the conversion ends. The converter drives the data line low while it converts and raises it when it finishes. The controller takes that rising edge as end of conversion. If the edge has not arrived within a fixed number of cycles, it proceeds anyway.

After the end of conversion the controller issues serial clock pulses and samples the data line on each rising clock edge. The frame arrives most significant bit first: a marker bit that should be 1, ten result bits, two sub-bits, and zeros after that. A short mode issues the 11 clocks needed for the marker and the result. A long mode issues 16 clocks, two whole bytes, which also collect the sub-bits. On the last falling clock edge the controller raises chip select and pulses done for one cycle. In that cycle it presents the result, the sub-bits and a framing-error flag. It then keeps chip select high for a programmed acquisition time before it accepts another start.

The clock divider, the conversion timeout and the acquisition wait are all counted in system clock cycles. An abort input can end a conversion wait early, and the acquisition wait applies after an abort as well.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high and in the cycle after reset, `cs_n_o` is 1, `sclk_o` is 0 and `done_o` is 0. A reset in the middle of a frame returns the outputs to these values on the next clock edge.
- R2: A high `start_i` while the controller is idle drives `cs_n_o` low at the next clock edge. `sclk_o` stays 0 for as long as the controller waits for end of conversion.
- R3: Once chip select is low, a 0-to-1 change on `sdi_i` ends the wait, and clocking starts before the timeout would have expired.
- R4: If `sdi_i` does not rise within `CONV_TMO` cycles after `cs_n_o` falls, clocking starts anyway, no earlier than `CONV_TMO` cycles after the fall.
- R5: `sclk_o` is 0 whenever `cs_n_o` is 1. While clocking, each half period of `sclk_o` lasts `DIV_HALF` cycles, so successive rising edges are `2*DIV_HALF` cycles apart.
- R6: With `mode16_i` = 0 exactly 11 rising edges of `sclk_o` occur per frame. With `mode16_i` = 1 exactly 16 occur.
- R7: Samples are counted from 1. Sample 1 is the marker. Samples 2 to 11 are result bits 9 down to 0. Samples 12 and 13 are `sub_o[1]` and `sub_o[0]`. In 11-clock mode `sub_o` reads 2'b00.
- R8: `cs_n_o` rises on the clock edge that ends the last falling `sclk_o` edge of the frame. `done_o` is high in that same cycle only, for exactly one cycle. `result_o` and `sub_o` hold their values until the next done.
- R9: `frame_err_o` is 1 in the done cycle exactly when the marker sample is 0. It is 0 in every other cycle.
- R10: After `cs_n_o` rises it stays high for at least `ACQ_WAIT` cycles. A `start_i` pulse during that time is ignored and is not remembered.
- R11: `abort_i` while waiting for end of conversion raises `cs_n_o` at the next edge without a done pulse. The acquisition wait of R10 then applies.
- R12: `mode16_i` is sampled only in the cycle a start is accepted. Changes during a frame do not alter that frame's clock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a conversion; taken only when idle |
| mode16_i | input | 1 | 1 selects the 16-clock mode, 0 selects the 11-clock mode |
| abort_i | input | 1 | Ends a conversion wait early |
| sdi_i | input | 1 | Data line from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock; idles low |
| done_o | output | 1 | One-cycle pulse when a frame is complete |
| result_o | output | DATA_W | Converted result, bit 9 first on the line |
| sub_o | output | SUB_W | Sub-bits; zero in 11-clock mode |
| frame_err_o | output | 1 | Marker sample was 0; valid with done_o |

## Verification
The bound checker watches the rules that hold every cycle:
- the serial clock stays low while chip select is high and during the conversion wait;
- done lasts one cycle, coincides with a fresh rise of chip select, and is the only cycle in which the framing flag may be high;
- chip select never falls again before the acquisition count has run out.

The bench's scenarios cover the rest, using a behavioural converter model that ends its conversion after a chosen delay or never:
- decoded values in both modes;
- the number of clock pulses and their spacing;
- whether clocking began on the data-line edge or on the timeout;
- a start ignored during recovery, an abort, a mode change during a frame, and a reset mid-frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_RECOV = 2'd3
  } rd_state_t;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_HALF = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int DC_W = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
  localparam logic [DC_W-1:0] DC_LAST = DC_W'(DIV_HALF - 1);

  logic [DC_W-1:0] dcnt;
  logic            flip;

  assign flip   = run_i && (dcnt == DC_LAST);
  assign rise_o = flip && !sclk_o;
  assign fall_o = flip && sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      dcnt   <= '0;
      sclk_o <= 1'b0;
    end else if (flip) begin
      dcnt   <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      dcnt   <= dcnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_eoc_det.sv
module adc_eoc_det #(
  parameter int CONV_TMO = 760
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic sdi_i,
  output logic sdi_q,
  output logic eoc_o,
  output logic tmo_o
);

  localparam int TC_W = $clog2(CONV_TMO + 1);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(CONV_TMO - 1);

  logic            sdi_qq;
  logic [TC_W-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdi_q  <= 1'b0;
      sdi_qq <= 1'b0;
    end else begin
      sdi_q  <= sdi_i;
      sdi_qq <= sdi_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !arm_i) begin
      tcnt <= '0;
    end else if (tcnt != TC_LAST) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  assign eoc_o = arm_i && sdi_q && !sdi_qq;
  assign tmo_o = arm_i && (tcnt == TC_LAST);

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int FRAME_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               smp_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);

  logic [FRAME_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pos <= {1'b1, {(FRAME_W-1){1'b0}}};
    end else if (smp_i) begin
      pos <= pos >> 1;
    end
  end

  for (genvar i = 0; i < FRAME_W; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        frame_o[i] <= 1'b0;
      end else if (smp_i && pos[i]) begin
        frame_o[i] <= bit_i;
      end
    end
  end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int SUB_W    = 2,
  parameter int DIV_HALF = 24,
  parameter int CONV_TMO = 760,
  parameter int ACQ_WAIT = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mode16_i,
  input  logic              abort_i,
  input  logic              sdi_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              frame_err_o
);

  localparam int FRAME_W    = 1 + DATA_W + SUB_W;
  localparam int SHORT_CLKS = 1 + DATA_W;
  localparam int LONG_CLKS  = ((FRAME_W + 7) / 8) * 8;
  localparam int CNT_W      = $clog2(LONG_CLKS + 1);
  localparam int ACQ_CW     = $clog2(ACQ_WAIT + 1);
  localparam logic [CNT_W-1:0]  LAST_SHORT = CNT_W'(SHORT_CLKS - 1);
  localparam logic [CNT_W-1:0]  LAST_LONG  = CNT_W'(LONG_CLKS - 1);
  localparam logic [ACQ_CW-1:0] ACQ_LAST   = ACQ_CW'(ACQ_WAIT - 1);

  rd_state_t          state;
  logic               long_q;
  logic [CNT_W-1:0]   fall_cnt;
  logic [ACQ_CW-1:0]  acq_cnt;
  logic               sc_rise, sc_fall, last_fall;
  logic               sdi_s, eoc, tmo;
  logic [FRAME_W-1:0] frame;

  adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .run_i  (state == ST_SHIFT),
    .sclk_o (sclk_o),
    .rise_o (sc_rise),
    .fall_o (sc_fall)
  );

  adc_eoc_det #(.CONV_TMO(CONV_TMO)) u_eoc (
    .clk   (clk),
    .rst   (rst),
    .arm_i (state == ST_CONV),
    .sdi_i (sdi_i),
    .sdi_q (sdi_s),
    .eoc_o (eoc),
    .tmo_o (tmo)
  );

  adc_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (state == ST_CONV),
    .smp_i   (sc_rise),
    .bit_i   (sdi_s),
    .frame_o (frame)
  );

  assign last_fall = sc_fall && (fall_cnt == (long_q ? LAST_LONG : LAST_SHORT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cs_n_o      <= 1'b1;
      done_o      <= 1'b0;
      frame_err_o <= 1'b0;
      result_o    <= '0;
      sub_o       <= '0;
      long_q      <= 1'b0;
      fall_cnt    <= '0;
      acq_cnt     <= '0;
    end else begin
      done_o      <= 1'b0;
      frame_err_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            cs_n_o <= 1'b0;
            long_q <= mode16_i;
            state  <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (abort_i) begin
            cs_n_o  <= 1'b1;
            acq_cnt <= '0;
            state   <= ST_RECOV;
          end else if (eoc || tmo) begin
            fall_cnt <= '0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (last_fall) begin
            cs_n_o      <= 1'b1;
            done_o      <= 1'b1;
            result_o    <= frame[FRAME_W-2 -: DATA_W];
            sub_o       <= frame[SUB_W-1:0];
            frame_err_o <= ~frame[FRAME_W-1];
            acq_cnt     <= '0;
            state       <= ST_RECOV;
          end else if (sc_fall) begin
            fall_cnt <= fall_cnt + 1'b1;
          end
        end
        ST_RECOV: begin
          if (acq_cnt == ACQ_LAST) begin
            state <= ST_IDLE;
          end else begin
            acq_cnt <= acq_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk
  import adc_rd_pkg::*;
#(
  parameter int ACQ_WAIT = 150
) (
  input logic      clk,
  input logic      rst,
  input logic      cs_n_o,
  input logic      sclk_o,
  input logic      done_o,
  input logic      frame_err_o,
  input rd_state_t state_i
);

  localparam int HC_W = $clog2(ACQ_WAIT + 1) + 1;
  localparam logic [HC_W-1:0] HI_SAT = HC_W'(ACQ_WAIT);

  logic [HC_W-1:0] hi_cnt;

  // Consecutive cycles with chip select high, saturating; reset counts as settled.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= HI_SAT;
    end else if (!cs_n_o) begin
      hi_cnt <= '0;
    end else if (hi_cnt != HI_SAT) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  p_conv_sclk_low_r2: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_CONV) |-> !sclk_o);

  p_done_with_cs_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(cs_n_o));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_err_only_done_r9: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> done_o);

  p_acq_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hi_cnt >= HI_SAT));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.ACQ_WAIT(ACQ_WAIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .done_o      (done_o),
  .frame_err_o (frame_err_o),
  .state_i     (state)
);

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;

  localparam int DH  = 2;
  localparam int TMO = 40;
  localparam int ACQ = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, mode16 = 1'b0, abort = 1'b0, sdi = 1'b1;
  logic cs_n, sclk, done, ferr;
  logic [9:0] res;
  logic [1:0] sub;

  always #5 clk = ~clk;

  adc_rd_ctrl #(.DATA_W(10), .SUB_W(2), .DIV_HALF(DH), .CONV_TMO(TMO), .ACQ_WAIT(ACQ)) dut (
    .clk(clk), .rst(rst), .start_i(start), .mode16_i(mode16), .abort_i(abort),
    .sdi_i(sdi), .cs_n_o(cs_n), .sclk_o(sclk), .done_o(done), .result_o(res),
    .sub_o(sub), .frame_err_o(ferr)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  // converter model and monitor, both at the falling clock edge
  logic [9:0] m_data = '0;
  logic [1:0] m_sub = '0;
  int m_delay = -1, m_cnt = 0, m_nfall = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;
  int lat = 0, rises = 0, first_lat = -1, last_rise = 0, per_err = 0;
  int hi_run = 0, last_hi = 0, done_cnt = 0, wide_done = 0;
  logic [9:0] cap_res; logic [1:0] cap_sub; logic cap_err, cap_cs;

  function automatic logic frame_bit(input int k);
    if (k >= 1 && k <= 10) return m_data[10-k];
    if (k == 11) return m_sub[1];
    if (k == 12) return m_sub[0];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    prev_cs <= cs_n; prev_sclk <= sclk; prev_done <= done;
    if (cs_n) begin
      sdi <= 1'b1; m_cnt <= 0; m_nfall <= 0;
    end else if (prev_cs) begin
      sdi <= 1'b0; m_cnt <= 0; m_nfall <= 0;
    end else begin
      m_cnt <= m_cnt + 1;
      if (prev_sclk && !sclk) begin
        m_nfall <= m_nfall + 1;
        sdi <= frame_bit(m_nfall + 1);
      end else if (m_nfall == 0 && m_delay >= 0 && m_cnt + 1 == m_delay) begin
        sdi <= 1'b1;
      end
    end
    if (!cs_n && prev_cs) begin
      lat <= 0; rises <= 0; first_lat <= -1; per_err <= 0;
      last_hi <= hi_run; hi_run <= 0;
    end else if (!cs_n) begin
      lat <= lat + 1;
      if (sclk && !prev_sclk) begin
        rises <= rises + 1; last_rise <= lat;
        if (rises == 0) first_lat <= lat;
        else if (lat - last_rise != 2 * DH) per_err <= per_err + 1;
      end
    end else begin
      hi_run <= hi_run + 1;
    end
    if (done) begin
      done_cnt <= done_cnt + 1;
      cap_res <= res; cap_sub <= sub; cap_err <= ferr; cap_cs <= cs_n;
      if (prev_done) wide_done <= wide_done + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input int dc0, input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_cnt != dc0) break;
    end
    @(negedge clk);
    chk(done_cnt == dc0 + 1, req, done_cnt - dc0, 1);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_frame(input bit md, input logic [9:0] d, input logic [1:0] s, input int dly);
    int dc0;
    m_data = d; m_sub = s; m_delay = dly; mode16 = md;
    dc0 = done_cnt;
    pulse_start();
    wait_done(dc0, "R8 done arrives");
    chk(cap_res == d, "R7 result", cap_res, d);
    chk(cap_sub == (md ? s : 2'b00), "R7 sub bits", cap_sub, md ? s : 0);
    chk(cap_err == (dly < 0), "R9 framing flag", cap_err, dly < 0);
    chk(rises == (md ? 16 : 11), "R6 clock count", rises, md ? 16 : 11);
    chk(per_err == 0, "R5 clock period", per_err, 0);
    chk(cap_cs == 1'b1, "R8 cs high at done", cap_cs, 1);
    if (dly >= 0)
      chk(first_lat >= dly && first_lat < TMO, "R3 edge ends wait", first_lat, dly);
    else
      chk(first_lat >= TMO, "R4 timeout start", first_lat, TMO);
    repeat (ACQ + 3) @(negedge clk);
  endtask

  // mode[20] data[19:10] sub[9:8] eoc delay[7:0], 8'hFF = never rises
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 10'h2A5, 2'b11, 8'd5},
    {1'b1, 10'h2A5, 2'b10, 8'd8},
    {1'b1, 10'h3FF, 2'b11, 8'd12},
    {1'b0, 10'h000, 2'b01, 8'd20},
    {1'b1, 10'h001, 2'b01, 8'd30},
    {1'b1, 10'h200, 2'b00, 8'd3},
    {1'b1, 10'h155, 2'b10, 8'hFF},
    {1'b0, 10'h0F0, 2'b11, 8'hFF}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 idle cs after reset", cs_n, 1);

    for (int v = 0; v < 8; v++) begin
      run_frame(VEC[v][20], VEC[v][19:10], VEC[v][9:8],
                (VEC[v][7:0] == 8'hFF) ? -1 : int'(VEC[v][7:0]));
    end

    // R2: chip select falls one edge after start
    m_delay = 6; mode16 = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(cs_n == 1'b0, "R2 cs falls after start", cs_n, 0);
    chk(sclk == 1'b0, "R2 sclk low in wait", sclk, 0);
    wait_done(done_cnt, "R2 frame completes");
    // R8: result held through recovery
    repeat (ACQ - 2) @(negedge clk);
    chk(res == cap_res, "R8 result held", res, cap_res);
    repeat (5) @(negedge clk);

    // R10: start during recovery ignored
    begin
      int dc0;
      m_data = 10'h3C3; m_sub = 2'b01; m_delay = 4; mode16 = 1'b1;
      dc0 = done_cnt;
      pulse_start();
      wait_done(dc0, "R10 setup frame");
      pulse_start();
      repeat (ACQ + 6) @(negedge clk);
      chk(cs_n == 1'b1, "R10 start ignored in recovery", cs_n, 1);
      chk(done_cnt == dc0 + 1, "R10 no extra frame", done_cnt - dc0, 1);
    end

    // R10: start held right after done, gap measured
    begin
      int dc0;
      dc0 = done_cnt;
      pulse_start();
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (done_cnt != dc0) break;
      end
      start = 1'b1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (!cs_n) break;
      end
      start = 1'b0;
      @(negedge clk);
      chk(last_hi >= ACQ, "R10 acquisition gap", last_hi, ACQ);
      wait_done(done_cnt, "R10 second frame");
      repeat (ACQ + 3) @(negedge clk);
    end

    // R11: abort during conversion wait
    begin
      int dc0;
      m_delay = -1;
      dc0 = done_cnt;
      pulse_start();
      repeat (4) @(negedge clk);
      abort = 1'b1;
      @(negedge clk) abort = 1'b0; start = 1'b1;
      chk(cs_n == 1'b1, "R11 abort raises cs", cs_n, 1);
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (!cs_n) break;
      end
      start = 1'b0;
      @(negedge clk);
      chk(last_hi >= ACQ, "R11 gap after abort", last_hi, ACQ);
      chk(done_cnt == dc0, "R11 no done on abort", done_cnt - dc0, 0);
      wait_done(dc0, "R11 next frame");
      repeat (ACQ + 3) @(negedge clk);
    end

    // R12: mode change during frame
    begin
      int dc0;
      m_data = 10'h0AA; m_sub = 2'b11; m_delay = 7; mode16 = 1'b1;
      dc0 = done_cnt;
      pulse_start();
      @(negedge clk) mode16 = 1'b0;
      wait_done(dc0, "R12 frame");
      chk(rises == 16, "R12 mode held", rises, 16);
      chk(cap_sub == 2'b11, "R12 sub in long mode", cap_sub, 3);
      repeat (ACQ + 3) @(negedge clk);
    end

    // R1: reset in the middle of clocking
    m_delay = 5; mode16 = 1'b1;
    pulse_start();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sclk) break;
    end
    rst = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 mid-frame reset cs", cs_n, 1);
    chk(sclk == 1'b0, "R1 mid-frame reset sclk", sclk, 0);
    chk(done == 1'b0, "R1 mid-frame reset done", done, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    chk(wide_done == 0, "R8 done one cycle", wide_done, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule